// File: doc/BRIEF.md
# Delayed write completion tracker

This block sits behind the target port of a bridge and turns non-posted writes into delayed transactions. When an initiator presents a write, the block compares it with the entries it already holds. A new write is stored: address, command, active-low byte enables and data. It is placed in a pending list and answered with a retry. Pending entries go one at a time to the far side, in arrival order, over a valid/ready handshake. The far side reports the end of the transfer with a done strobe, which may carry an error flag.

A completed entry waits for the initiator to come back with the same write. Only data lanes whose byte enable is active take part in the comparison. A repeat that arrives before the far side has finished is retried again and never takes a second slot. A repeat that arrives after completion gets a normal or an error status and releases the slot.

Completed entries form an ordered completion list. Only the oldest completed entry runs a discard timer, loaded from a programmable reload input. If that timer runs out before the initiator returns, the entry is dropped. A one-cycle system-error strobe is also raised when the error enable input is set.

Top module: `dlyw_tracker`

## Requirements
- R1: A write presented with `req_valid` that matches no entry, while a slot is free, takes a slot. On the next cycle `rsp_valid` is high with `rsp_code` 2'b00 (retry), and `q_count` has risen by one.
- R2: A write that matches a held entry which is pending or in flight is answered with retry (2'b00), and `q_count` does not change.
- R3: A match requires equal address, command and byte enables. Data is compared only on lanes whose `req_be_n` bit is 0. Lane k is bits 8k+7..8k and bit 1 means the lane is disabled. A byte difference on an enabled lane makes the write a new entry.
- R4: With all DEPTH slots in use, `q_full` is 1. A non-matching write is then answered with retry and no slot is taken.
- R5: `fwd_valid` presents the oldest pending entry on the `fwd_*` outputs, in arrival order, and at most one entry is in flight. A cycle with `fwd_valid` and `fwd_ready` both high moves that entry to in flight, and `fwd_valid` stays low until `cmpl_done`.
- R6: `cmpl_done` with `cmpl_err` low completes the in-flight entry (`cq_count` rises). A later matching write is answered with 2'b01 (accept), and its slot is freed.
- R7: `cmpl_done` with `cmpl_err` high completes the entry with error. A later matching write is answered with 2'b10 (abort), and its slot is freed.
- R8: The discard timer runs only for the oldest completed entry. With reload value N, an entry that completes at edge e and stays oldest is removed at edge e+N+1 when not repeated.
- R9: On a timer removal, `serr_pulse` is high for exactly one cycle, and only if `serr_en` is 1.
- R10: A reload value of 0 removes an entry at the first edge after it becomes the oldest completed entry.
- R11: A matching write in the same cycle as the timer expiry of that entry wins. It is answered with accept, the entry is freed and no `serr_pulse` follows.
- R12: When the oldest completed entry leaves, the next one becomes oldest and starts a fresh timer from that cycle. It is removed N+1 edges after the leaving edge.
- R13: After reset, no slot is in use, and `rsp_valid`, `fwd_valid` and `serr_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A write data phase is presented this cycle |
| req_addr | input | AW | Write address |
| req_cmd | input | CW | Write command code |
| req_be_n | input | BW | Byte enables, active low |
| req_data | input | DW | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's write |
| rsp_code | output | 2 | 00 retry, 01 accept, 10 abort |
| fwd_valid | output | 1 | Oldest pending entry offered to the far side |
| fwd_ready | input | 1 | Far side takes the offered entry |
| fwd_addr | output | AW | Offered entry address |
| fwd_cmd | output | CW | Offered entry command |
| fwd_be_n | output | BW | Offered entry byte enables |
| fwd_data | output | DW | Offered entry data |
| cmpl_done | input | 1 | Far side finished the in-flight entry |
| cmpl_err | input | 1 | Finished with error (valid with cmpl_done) |
| tmr_reload | input | TW | Discard timer reload value |
| serr_en | input | 1 | Enables the system-error strobe |
| q_count | output | CW2 | Slots in use |
| q_full | output | 1 | Every slot in use |
| cq_count | output | CW2 | Completed entries waiting for their initiator |
| serr_pulse | output | 1 | One-cycle strobe on a timer discard |

## Verification
Two events can land in the same cycle. One is the expiry of the discard timer on the oldest completed entry. The other is the initiator's repeat of that very write. The bench lets the timer count down to its final cycle with a known reload value, then presents the matching write in exactly that cycle. It expects an accept response, an empty slot array and no error strobe, because a timer that won would have shown retry-free removal plus a strobe. A separate test hands the timer over to a second completed entry, to show that it starts fresh rather than having run in the background.

// File: rtl/dlyw_pkg.sv
package dlyw_pkg;

  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_WAIT = 2'd1,
    SL_FLY  = 2'd2,
    SL_DONE = 2'd3
  } slot_st_t;

  localparam logic [1:0] RSP_RETRY  = 2'b00;
  localparam logic [1:0] RSP_ACCEPT = 2'b01;
  localparam logic [1:0] RSP_ABORT  = 2'b10;

endpackage

// File: rtl/dlyw_match.sv
module dlyw_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int CW    = 4,
  parameter int BW    = 4,
  parameter int DW    = BW * 8,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]         live,
  input  logic [DEPTH-1:0][AW-1:0] s_addr,
  input  logic [DEPTH-1:0][CW-1:0] s_cmd,
  input  logic [DEPTH-1:0][BW-1:0] s_be_n,
  input  logic [DEPTH-1:0][DW-1:0] s_data,
  input  logic [AW-1:0]            q_addr,
  input  logic [CW-1:0]            q_cmd,
  input  logic [BW-1:0]            q_be_n,
  input  logic [DW-1:0]            q_data,
  output logic [DEPTH-1:0]         hit_vec,
  output logic                     hit,
  output logic [IW-1:0]            hit_idx
);

  // lanes with an active (low) enable become all-ones in the mask
  function automatic logic [DW-1:0] lane_mask(input logic [BW-1:0] be_n);
    logic [DW-1:0] m;
    for (int b = 0; b < BW; b++) m[b*8 +: 8] = {8{~be_n[b]}};
    return m;
  endfunction

  function automatic logic lanes_agree(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                       input logic [BW-1:0] be_n);
    return ((a ^ b) & lane_mask(be_n)) == '0;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = live[i] && (s_addr[i] == q_addr) && (s_cmd[i] == q_cmd) &&
                        (s_be_n[i] == q_be_n) && lanes_agree(s_data[i], q_data, q_be_n);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (hit_vec[i]) hit_idx = IW'(i);
  end

endmodule

// File: rtl/dlyw_discard_timer.sv
module dlyw_discard_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_present,
  input  logic          head_leave,
  input  logic [TW-1:0] reload,
  output logic          expire
);

  logic          armed;
  logic [TW-1:0] tmr;

  assign expire = head_present && (armed ? (tmr == '0) : (reload == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tmr   <= '0;
    end else if (!head_present || head_leave) begin
      armed <= 1'b0;
    end else if (!armed) begin
      armed <= 1'b1;
      tmr   <= (reload == '0) ? '0 : reload - TW'(1);
    end else if (tmr != '0) begin
      tmr <= tmr - TW'(1);
    end
  end

  // R8: an armed timer that kept its head counts down by one each cycle
  p_tmr_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(armed && head_present && !head_leave) |-> tmr == $past(tmr) - TW'(1));

endmodule

// File: rtl/dlyw_tracker.sv
module dlyw_tracker
  import dlyw_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int CW    = 4,
  parameter int BW    = 4,
  parameter int DW    = BW * 8,
  parameter int TW    = 8,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW2   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [CW-1:0]  req_cmd,
  input  logic [BW-1:0]  req_be_n,
  input  logic [DW-1:0]  req_data,
  output logic           rsp_valid,
  output logic [1:0]     rsp_code,
  output logic           fwd_valid,
  input  logic           fwd_ready,
  output logic [AW-1:0]  fwd_addr,
  output logic [CW-1:0]  fwd_cmd,
  output logic [BW-1:0]  fwd_be_n,
  output logic [DW-1:0]  fwd_data,
  input  logic           cmpl_done,
  input  logic           cmpl_err,
  input  logic [TW-1:0]  tmr_reload,
  input  logic           serr_en,
  output logic [CW2-1:0] q_count,
  output logic           q_full,
  output logic [CW2-1:0] cq_count,
  output logic           serr_pulse
);

  // slot storage
  slot_st_t                st    [DEPTH];
  logic [IW-1:0]           prank [DEPTH];
  logic [IW-1:0]           crank [DEPTH];
  logic [DEPTH-1:0]        errf;
  logic [DEPTH-1:0][AW-1:0] s_addr;
  logic [DEPTH-1:0][CW-1:0] s_cmd;
  logic [DEPTH-1:0][BW-1:0] s_be_n;
  logic [DEPTH-1:0][DW-1:0] s_data;

  // named internal events
  logic [DEPTH-1:0] live, is_wait, is_fly, is_done, hit_vec, leave;
  logic             hit, hit_done, rep_accept, alloc, dispatch, fin, expire, discard;
  logic             free_any, ph_vld, h_vld, head_leave;
  logic [IW-1:0]    hit_idx, free_idx, ph_idx, h_idx;
  logic [CW2-1:0]   pcnt, dcnt, lcnt;
  logic [IW-1:0]    prank_new, crank_new;
  logic [IW-1:0]    crank_nx [DEPTH];
  logic [1:0]       rsp_nx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i]    = (st[i] != SL_FREE);
      is_wait[i] = (st[i] == SL_WAIT);
      is_fly[i]  = (st[i] == SL_FLY);
      is_done[i] = (st[i] == SL_DONE);
    end
  end

  dlyw_match #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .BW(BW), .DW(DW), .IW(IW)) u_match (
    .live    (live),
    .s_addr  (s_addr),
    .s_cmd   (s_cmd),
    .s_be_n  (s_be_n),
    .s_data  (s_data),
    .q_addr  (req_addr),
    .q_cmd   (req_cmd),
    .q_be_n  (req_be_n),
    .q_data  (req_data),
    .hit_vec (hit_vec),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  // lowest free slot, pending head, completion head
  always_comb begin
    free_any = 1'b0; free_idx = '0;
    ph_vld   = 1'b0; ph_idx   = '0;
    h_vld    = 1'b0; h_idx    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!live[i]) begin free_any = 1'b1; free_idx = IW'(i); end
      if (is_wait[i] && prank[i] == '0) begin ph_vld = 1'b1; ph_idx = IW'(i); end
      if (is_done[i] && crank[i] == '0) begin h_vld = 1'b1; h_idx = IW'(i); end
    end
  end

  assign hit_done   = hit && is_done[hit_idx];
  assign rep_accept = req_valid && hit_done;
  assign alloc      = req_valid && !hit && free_any;
  assign fwd_valid  = ph_vld && !(|is_fly);
  assign dispatch   = fwd_valid && fwd_ready;
  assign fin        = cmpl_done && (|is_fly);

  assign fwd_addr = s_addr[ph_idx];
  assign fwd_cmd  = s_cmd[ph_idx];
  assign fwd_be_n = s_be_n[ph_idx];
  assign fwd_data = s_data[ph_idx];

  dlyw_discard_timer #(.TW(TW)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_present (h_vld),
    .head_leave   (head_leave),
    .reload       (tmr_reload),
    .expire       (expire)
  );

  // a repeat of the head in the expiry cycle takes precedence over the discard
  assign discard = expire && !(rep_accept && hit_idx == h_idx);

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      leave[i] = (rep_accept && hit_idx == IW'(i)) || (discard && h_idx == IW'(i));
  end

  assign head_leave = h_vld && leave[h_idx];

  assign pcnt = CW2'($countones(is_wait));
  assign dcnt = CW2'($countones(is_done));
  assign lcnt = CW2'($countones(leave));
  assign prank_new = IW'(pcnt - (dispatch ? CW2'(1) : CW2'(0)));
  assign crank_new = IW'(dcnt - lcnt);

  // completed entries close the gaps left by departures ahead of them
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      crank_nx[i] = crank[i];
      for (int j = 0; j < DEPTH; j++)
        if (leave[j] && is_done[j] && crank[j] < crank[i]) crank_nx[i] = crank_nx[i] - IW'(1);
    end
  end

  always_comb begin
    rsp_nx = RSP_RETRY;
    if (hit_done) rsp_nx = errf[hit_idx] ? RSP_ABORT : RSP_ACCEPT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i]    <= SL_FREE;
        prank[i] <= '0;
        crank[i] <= '0;
      end
      errf       <= '0;
      s_addr     <= '0;
      s_cmd      <= '0;
      s_be_n     <= '0;
      s_data     <= '0;
      rsp_valid  <= 1'b0;
      rsp_code   <= RSP_RETRY;
      serr_pulse <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_code   <= rsp_nx;
      serr_pulse <= discard && serr_en;
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc && free_idx == IW'(i)) begin
          st[i]     <= SL_WAIT;
          prank[i]  <= prank_new;
          errf[i]   <= 1'b0;
          s_addr[i] <= req_addr;
          s_cmd[i]  <= req_cmd;
          s_be_n[i] <= req_be_n;
          s_data[i] <= req_data;
        end else if (is_wait[i]) begin
          if (dispatch && ph_idx == IW'(i)) st[i] <= SL_FLY;
          else if (dispatch)                prank[i] <= prank[i] - IW'(1);
        end else if (is_fly[i]) begin
          if (fin) begin
            st[i]    <= SL_DONE;
            errf[i]  <= cmpl_err;
            crank[i] <= crank_new;
          end
        end else if (is_done[i]) begin
          if (leave[i]) st[i] <= SL_FREE;
          else          crank[i] <= crank_nx[i];
        end
      end
    end
  end

  assign q_count  = CW2'($countones(live));
  assign q_full   = &live;
  assign cq_count = dcnt;

  // R2: a write never matches two slots, so repeats never duplicated an entry
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));

  // R2: a repeat never adds to the occupancy
  p_repeat_no_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit |=> q_count <= $past(q_count));

  // R4: a write that finds the slots full leaves the occupancy unchanged or lower
  p_full_no_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && q_full && !hit |=> q_count <= $past(q_count));

  // R5: never more than one entry with the far side
  p_one_flight_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(is_fly));

  // R1: a response only follows a presented write
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R6: an accepted repeat releases a slot
  p_accept_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_accept |=> q_count < $past(q_count));

  // R8: a discard takes an entry off the completion list
  p_discard_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> cq_count <= $past(cq_count));

endmodule

// File: tb/dlyw_tracker_bench.sv
module dlyw_tracker_bench;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [3:0]  req_cmd;
  logic [3:0]  req_be_n;
  logic [31:0] req_data;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic        fwd_valid, fwd_ready;
  logic [31:0] fwd_addr;
  logic [3:0]  fwd_cmd;
  logic [3:0]  fwd_be_n;
  logic [31:0] fwd_data;
  logic        cmpl_done, cmpl_err;
  logic [7:0]  tmr_reload;
  logic        serr_en;
  logic [2:0]  q_count, cq_count;
  logic        q_full, serr_pulse;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  dlyw_tracker u_dlyw_tracker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
    .req_be_n(req_be_n), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
    .fwd_cmd(fwd_cmd), .fwd_be_n(fwd_be_n), .fwd_data(fwd_data),
    .cmpl_done(cmpl_done), .cmpl_err(cmpl_err),
    .tmr_reload(tmr_reload), .serr_en(serr_en),
    .q_count(q_count), .q_full(q_full), .cq_count(cq_count), .serr_pulse(serr_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] a, input logic [3:0] c, input logic [3:0] ben,
                      input logic [31:0] d);
    req_valid = 1'b1; req_addr = a; req_cmd = c; req_be_n = ben; req_data = d;
    step();
    req_valid = 1'b0;
  endtask

  task automatic dispatch_one();
    fwd_ready = 1'b1;
    step();
    fwd_ready = 1'b0;
  endtask

  task automatic done_one(input logic e);
    cmpl_done = 1'b1; cmpl_err = e;
    step();
    cmpl_done = 1'b0; cmpl_err = 1'b0;
  endtask

  task automatic drain();
    tmr_reload = 8'd0; serr_en = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin dispatch_one(); done_one(1'b0); end
    for (int k = 0; k < DEPTH + 2; k++) step();
    serr_en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R13 q_count", q_count, 0);
    chk("R13 rsp_valid", rsp_valid, 0);
    chk("R13 fwd_valid", fwd_valid, 0);
    chk("R13 serr_pulse", serr_pulse, 0);
    chk("R13 cq_count", cq_count, 0);
  endtask

  task automatic t_alloc_repeat();
    tmr_reload = 8'd200;
    send(32'h1000, 4'h7, 4'h0, 32'hCAFE0001);
    chk("R1 rsp_valid", rsp_valid, 1);
    chk("R1 rsp_code retry", rsp_code, 0);
    chk("R1 q_count", q_count, 1);
    chk("R1 fwd_valid", fwd_valid, 1);
    send(32'h1000, 4'h7, 4'h0, 32'hCAFE0001);
    chk("R2 pending repeat retry", rsp_code, 0);
    chk("R2 pending repeat no entry", q_count, 1);
    dispatch_one();
    send(32'h1000, 4'h7, 4'h0, 32'hCAFE0001);
    chk("R2 in-flight repeat retry", rsp_code, 0);
    chk("R2 in-flight repeat no entry", q_count, 1);
    drain();
  endtask

  task automatic t_lanes();
    tmr_reload = 8'd200;
    // lanes 1 and 3 enabled (be_n = 0101)
    send(32'h2000, 4'h7, 4'b0101, 32'h11223344);
    send(32'h2000, 4'h7, 4'b0101, 32'h11FF33EE);
    chk("R3 disabled lanes ignored", q_count, 1);
    send(32'h2000, 4'h7, 4'b0101, 32'h12223344);
    chk("R3 enabled lane differs", q_count, 2);
    send(32'h2000, 4'h7, 4'b0100, 32'h11223344);
    chk("R3 enables differ", q_count, 3);
    drain();
  endtask

  task automatic t_full();
    tmr_reload = 8'd200;
    for (int k = 0; k < DEPTH; k++) send(32'h100 + 32'(k * 4), 4'h7, 4'h0, 32'(k));
    chk("R4 q_full", q_full, 1);
    chk("R4 q_count", q_count, DEPTH);
    send(32'h200, 4'h7, 4'h0, 32'h5);
    chk("R4 full retry", rsp_code, 0);
    chk("R4 full no entry", q_count, DEPTH);
    drain();
    chk("R4 drained", q_count, 0);
  endtask

  task automatic t_order();
    tmr_reload = 8'd200;
    send(32'h300, 4'h7, 4'h0, 32'hA);
    send(32'h304, 4'h7, 4'h0, 32'hB);
    chk("R5 oldest first", fwd_addr, 32'h300);
    dispatch_one();
    chk("R5 one in flight", fwd_valid, 0);
    done_one(1'b0);
    chk("R5 next offered", fwd_valid, 1);
    chk("R5 next address", fwd_addr, 32'h304);
    drain();
  endtask

  task automatic t_accept();
    tmr_reload = 8'd200;
    send(32'h400, 4'h3, 4'h0, 32'h44);
    dispatch_one();
    done_one(1'b0);
    chk("R6 completed", cq_count, 1);
    send(32'h400, 4'h3, 4'h0, 32'h44);
    chk("R6 accept code", rsp_code, 1);
    chk("R6 slot freed", q_count, 0);
    send(32'h400, 4'h3, 4'h0, 32'h44);
    chk("R6 later write is new", q_count, 1);
    drain();
  endtask

  task automatic t_abort();
    tmr_reload = 8'd200;
    send(32'h500, 4'h3, 4'h0, 32'h55);
    dispatch_one();
    done_one(1'b1);
    send(32'h500, 4'h3, 4'h0, 32'h55);
    chk("R7 abort code", rsp_code, 2);
    chk("R7 slot freed", q_count, 0);
  endtask

  task automatic t_discard(input int n, input logic en);
    tmr_reload = 8'(n); serr_en = en;
    send(32'h600, 4'h7, 4'h0, 32'h66);
    dispatch_one();
    done_one(1'b0);
    for (int k = 0; k <= n; k++) begin
      chk("R8 held until expiry", cq_count, 1);
      chk("R9 no early strobe", serr_pulse, 0);
      step();
    end
    chk("R8 removed on expiry", q_count, 0);
    chk("R9 strobe follows enable", serr_pulse, en ? 1 : 0);
    step();
    chk("R9 strobe one cycle", serr_pulse, 0);
    serr_en = 1'b1;
  endtask

  task automatic t_zero();
    tmr_reload = 8'd0;
    send(32'h700, 4'h7, 4'h0, 32'h77);
    dispatch_one();
    done_one(1'b0);
    chk("R10 present at head", cq_count, 1);
    step();
    chk("R10 removed next edge", q_count, 0);
    chk("R10 strobe", serr_pulse, 1);
    step();
  endtask

  task automatic t_collide();
    tmr_reload = 8'd4;
    send(32'h800, 4'h7, 4'h0, 32'h88);
    dispatch_one();
    done_one(1'b0);
    for (int k = 0; k < 4; k++) step();
    send(32'h800, 4'h7, 4'h0, 32'h88);
    chk("R11 repeat wins", rsp_code, 1);
    chk("R11 no strobe", serr_pulse, 0);
    chk("R11 freed", q_count, 0);
    step();
    chk("R11 no late strobe", serr_pulse, 0);
  endtask

  task automatic t_handoff();
    tmr_reload = 8'd5;
    send(32'h900, 4'h7, 4'h0, 32'h91);
    send(32'h904, 4'h7, 4'h0, 32'h92);
    dispatch_one();
    done_one(1'b0);
    dispatch_one();
    done_one(1'b0);
    chk("R12 two completed", cq_count, 2);
    send(32'h900, 4'h7, 4'h0, 32'h91);
    chk("R12 first accepted", rsp_code, 1);
    for (int k = 0; k <= 5; k++) begin
      chk("R12 fresh timer holds", cq_count, 1);
      step();
    end
    chk("R12 removed after fresh count", cq_count, 0);
    chk("R12 strobe", serr_pulse, 1);
    step();
  endtask

  initial begin
    #(8 * 100000);
    if (!ended) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_cmd = '0; req_be_n = '0;
    req_data = '0; fwd_ready = 1'b0; cmpl_done = 1'b0; cmpl_err = 1'b0;
    tmr_reload = 8'd0; serr_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_repeat();
    t_lanes();
    t_full();
    t_order();
    t_accept();
    t_abort();
    t_discard(3, 1'b1);
    t_discard(2, 1'b0);
    t_zero();
    t_collide();
    t_handoff();
    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule